// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block joins two data ports, A and B, through one storage latch per direction. Each direction has three active-low controls: an enable, a latch enable and an output enable. When the enable and the latch enable of a direction are both low, its latch is open. The far port then follows the near port. A rising edge on either control closes the latch, and the captured word is kept until the latch is opened again. The output enable and the enable together decide whether the far port drives. Capture works the same way whether the port is driving or not.

No tri-state nets are used. Each port is split into an input vector, an output data vector and a per-section drive flag. The surrounding logic or pad ring turns these into a bus. The block is built from `NUM_SECT` independent sections of `SECT_W` bits, each with its own six controls. The default configuration is two 8-bit sections.

The block contains only level-sensitive storage and has no clock. A valid/ready interface does not fit a transparent path, so the data ports are plain vectors with no back-pressure. An active-low power-up reset, `pwr_rst_n`, holds every port undriven and clears the latches.

Top module: `bxcvr_latched`

## Requirements
- R1: With the A-to-B enable, latch enable and output enable of a section all low, that section's `b_out` slice equals its `a_in` slice and follows every change of it.
- R2: A rising edge of the A-to-B latch enable, with the enable held low, captures the `a_in` slice. After that, `b_out` keeps the captured word while `a_in` changes.
- R3: A rising edge of the A-to-B enable, with the latch enable held low, also captures the `a_in` slice. The captured word is shown once the enable is lowered again with the latch enable high.
- R4: A section's `b_oe` bit is 1 exactly when `pwr_rst_n` is 1 and that section's A-to-B output enable and enable are both 0. While `b_oe` is 0, the `b_out` slice is all zeros.
- R5: The B-to-A direction follows R1 to R4, using its own three controls, `b_in`, `a_out` and `a_oe`.
- R6: A word captured while the output enable is high appears on the output once the output enable goes low, provided the latch is closed by then.
- R7: With the enable low and the latch enable high, input changes do not alter the stored word or the output.
- R8: Controls and data of one section have no effect on the stored words or outputs of any other section.
- R9: While `pwr_rst_n` is 0, all `a_oe` and `b_oe` bits are 0 and every latch is cleared to zero. After release, an output enabled in hold mode shows zero until new data is captured.
- R10: Both directions of a section may drive at the same time. Each port then shows its own direction's stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwr_rst_n | input | 1 | Active-low power-up reset |
| ab_en_n | input | NUM_SECT | A-to-B enable per section, active low |
| ab_le_n | input | NUM_SECT | A-to-B latch enable per section, active low |
| ab_oe_n | input | NUM_SECT | A-to-B output enable per section, active low |
| ba_en_n | input | NUM_SECT | B-to-A enable per section, active low |
| ba_le_n | input | NUM_SECT | B-to-A latch enable per section, active low |
| ba_oe_n | input | NUM_SECT | B-to-A output enable per section, active low |
| a_in | input | NUM_SECT*SECT_W | Value seen on port A |
| a_out | output | NUM_SECT*SECT_W | Data to drive onto port A |
| a_oe | output | NUM_SECT | Port A drive flag per section |
| b_in | input | NUM_SECT*SECT_W | Value seen on port B |
| b_out | output | NUM_SECT*SECT_W | Data to drive onto port B |
| b_oe | output | NUM_SECT | Port B drive flag per section |

## Verification
A latch that stays open after its gate closes shows up immediately: the output follows the next input change in hold mode. A latch that never opens shows up just as fast, because the output lags the input in transparent mode. A wrong stored word captured while disabled stays invisible until the output enable is lowered. It then appears on the very next sample. So every capture case is checked both in hold mode and after a later enable. Crossed section or direction wiring shows up when the untouched section is enabled and its word is not zero or not its own.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  // Index of each direction inside a section.
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int NUM_DIR = 2;

  // Active-low control triple for one direction.
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;
endpackage

// File: rtl/bxcvr_store.sv
module bxcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             pwr_rst_n,
  input  logic             en_n,
  input  logic             le_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic gate_open;

  // Transparent only while both enables are low; either rising closes it.
  assign gate_open = ~en_n & ~le_n;

  always_latch begin
    if (!pwr_rst_n)
      q = '0;
    else if (gate_open)
      q = d;
  end

  // R9
  always_comb begin
    if (!pwr_rst_n)
      store_clear_chk: assert (q == '0);
  end
endmodule

// File: rtl/bxcvr_drive.sv
module bxcvr_drive #(
  parameter int WIDTH = 8
) (
  input  logic             pwr_rst_n,
  input  logic             en_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] dout,
  output logic             doe
);
  always_comb begin
    doe  = pwr_rst_n & ~en_n & ~oe_n;
    dout = doe ? q : '0;
  end
endmodule

// File: rtl/bxcvr_section.sv
module bxcvr_section
  import bxcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                           pwr_rst_n,
  input  dir_ctl_t [NUM_DIR-1:0]         ctl,
  input  logic [NUM_DIR-1:0][WIDTH-1:0]  din,
  output logic [NUM_DIR-1:0][WIDTH-1:0]  dout,
  output logic [NUM_DIR-1:0]             doe
);
  logic [NUM_DIR-1:0][WIDTH-1:0] stored;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    bxcvr_store #(.WIDTH(WIDTH)) u_store (
      .pwr_rst_n (pwr_rst_n),
      .en_n      (ctl[d].en_n),
      .le_n      (ctl[d].le_n),
      .d         (din[d]),
      .q         (stored[d])
    );

    bxcvr_drive #(.WIDTH(WIDTH)) u_drive (
      .pwr_rst_n (pwr_rst_n),
      .en_n      (ctl[d].en_n),
      .oe_n      (ctl[d].oe_n),
      .q         (stored[d]),
      .dout      (dout[d]),
      .doe       (doe[d])
    );

    // R1
    always_comb begin
      if (pwr_rst_n && !ctl[d].en_n && !ctl[d].le_n && !ctl[d].oe_n)
        transparent_follow_chk: assert (dout[d] == din[d]);
    end

    // R4
    always_comb begin
      if (!doe[d])
        idle_output_zero_chk: assert (dout[d] == '0);
    end
  end
endmodule

// File: rtl/bxcvr_latched.sv
module bxcvr_latched
  import bxcvr_pkg::*;
#(
  parameter int SECT_W   = 8,
  parameter int NUM_SECT = 2
) (
  input  logic                         pwr_rst_n,
  input  logic [NUM_SECT-1:0]          ab_en_n,
  input  logic [NUM_SECT-1:0]          ab_le_n,
  input  logic [NUM_SECT-1:0]          ab_oe_n,
  input  logic [NUM_SECT-1:0]          ba_en_n,
  input  logic [NUM_SECT-1:0]          ba_le_n,
  input  logic [NUM_SECT-1:0]          ba_oe_n,
  input  logic [NUM_SECT*SECT_W-1:0]   a_in,
  output logic [NUM_SECT*SECT_W-1:0]   a_out,
  output logic [NUM_SECT-1:0]          a_oe,
  input  logic [NUM_SECT*SECT_W-1:0]   b_in,
  output logic [NUM_SECT*SECT_W-1:0]   b_out,
  output logic [NUM_SECT-1:0]          b_oe
);
  localparam int BUS_W = NUM_SECT * SECT_W;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    dir_ctl_t [NUM_DIR-1:0]         ctl;
    logic [NUM_DIR-1:0][SECT_W-1:0] din;
    logic [NUM_DIR-1:0][SECT_W-1:0] dout;
    logic [NUM_DIR-1:0]             doe;

    assign ctl[DIR_AB] = '{en_n: ab_en_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
    assign ctl[DIR_BA] = '{en_n: ba_en_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};
    assign din[DIR_AB] = a_in[s*SECT_W +: SECT_W];
    assign din[DIR_BA] = b_in[s*SECT_W +: SECT_W];

    bxcvr_section #(.WIDTH(SECT_W)) u_sect (
      .pwr_rst_n (pwr_rst_n),
      .ctl       (ctl),
      .din       (din),
      .dout      (dout),
      .doe       (doe)
    );

    assign b_out[s*SECT_W +: SECT_W] = dout[DIR_AB];
    assign b_oe[s]                   = doe[DIR_AB];
    assign a_out[s*SECT_W +: SECT_W] = dout[DIR_BA];
    assign a_oe[s]                   = doe[DIR_BA];
  end

  // R9
  always_comb begin
    if (!pwr_rst_n)
      reset_undriven_chk: assert (a_oe == '0 && b_oe == '0);
  end

  // R4
  always_comb begin
    if (b_oe == '0)
      bus_quiet_chk: assert (b_out == {BUS_W{1'b0}});
  end
endmodule

// File: tb/bxcvr_latched_test.sv
module bxcvr_latched_test;
  localparam int W  = 8;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          pwr_rst_n;
  logic [NS-1:0] ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
  logic [NS*W-1:0] a_in, a_out, b_in, b_out;
  logic [NS-1:0]   a_oe, b_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bxcvr_latched #(.SECT_W(W), .NUM_SECT(NS)) uut (
    .pwr_rst_n (pwr_rst_n),
    .ab_en_n (ab_en_n), .ab_le_n (ab_le_n), .ab_oe_n (ab_oe_n),
    .ba_en_n (ba_en_n), .ba_le_n (ba_le_n), .ba_oe_n (ba_oe_n),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // dir 0 = A to B, dir 1 = B to A
  task automatic set_ctl(input int s, input int dir, input bit en, input bit le, input bit oe);
    if (dir == 0) begin
      ab_en_n[s] = en; ab_le_n[s] = le; ab_oe_n[s] = oe;
    end else begin
      ba_en_n[s] = en; ba_le_n[s] = le; ba_oe_n[s] = oe;
    end
  endtask

  task automatic put(input int s, input int dir, input int v);
    if (dir == 0) a_in[s*W +: W] = v[W-1:0];
    else          b_in[s*W +: W] = v[W-1:0];
  endtask

  function automatic int got(input int s, input int dir);
    return (dir == 0) ? int'(b_out[s*W +: W]) : int'(a_out[s*W +: W]);
  endfunction

  function automatic int got_oe(input int s, input int dir);
    return (dir == 0) ? int'(b_oe[s]) : int'(a_oe[s]);
  endfunction

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    pwr_rst_n = 1'b0;
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
    a_in = '0; b_in = '0;
    settle();
    // R9: nothing drives in reset, even with every control low
    ab_en_n = '0; ab_le_n = '0; ab_oe_n = '0;
    ba_en_n = '0; ba_le_n = '0; ba_oe_n = '0;
    a_in = '1; b_in = '1;
    settle();
    chk("R9 reset a_oe", int'(a_oe), 0);
    chk("R9 reset b_oe", int'(b_oe), 0);
    // release into hold mode: cleared latches must show zero
    ab_le_n = '1; ba_le_n = '1;
    settle();
    pwr_rst_n = 1'b1;
    settle();
    chk("R9 cleared b_out", int'(b_out), 0);
    chk("R9 cleared a_out", int'(a_out), 0);
    ab_en_n = '1; ab_oe_n = '1; ba_en_n = '1; ba_oe_n = '1;
    a_in = '0; b_in = '0;
    settle();

    for (int s = 0; s < NS; s++) begin
      for (int dir = 0; dir < 2; dir++) begin
        int last;
        // R4 / R5: drive flag over en and oe, latch held
        for (int c = 0; c < 4; c++) begin
          set_ctl(s, dir, c[0], 1'b1, c[1]);
          settle();
          chk(dir == 0 ? "R4 drive flag" : "R5 drive flag", got_oe(s, dir), (c == 0) ? 1 : 0);
          if (c != 0) chk(dir == 0 ? "R4 idle zero" : "R5 idle zero", got(s, dir), 0);
        end
        // R1 / R5: transparent sweep
        set_ctl(s, dir, 1'b0, 1'b0, 1'b0);
        last = 0;
        for (int v = 0; v < 16; v++) begin
          last = ((v * 17) ^ (s * 90) ^ (dir * 3)) & 8'hff;
          put(s, dir, last);
          settle();
          chk(dir == 0 ? "R1 transparent" : "R5 transparent", got(s, dir), last);
        end
        // R2: latch enable rising captures
        set_ctl(s, dir, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R2 captured", got(s, dir), last);
        // R7: hold ignores input
        for (int v = 0; v < 4; v++) begin
          put(s, dir, last ^ (8'h81 << v));
          settle();
          chk("R7 hold", got(s, dir), last);
        end
        // R3: enable rising captures
        set_ctl(s, dir, 1'b0, 1'b0, 1'b0);
        put(s, dir, 8'h3c ^ s);
        settle();
        set_ctl(s, dir, 1'b1, 1'b0, 1'b0);
        settle();
        chk("R3 disabled by en", got_oe(s, dir), 0);
        put(s, dir, 8'hc3);
        settle();
        set_ctl(s, dir, 1'b1, 1'b1, 1'b0);
        settle();
        set_ctl(s, dir, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R3 en capture", got(s, dir), 8'h3c ^ s);
        // R6: capture while output disabled
        set_ctl(s, dir, 1'b0, 1'b0, 1'b1);
        put(s, dir, 8'ha5 ^ dir);
        settle();
        chk("R6 undriven", got_oe(s, dir), 0);
        set_ctl(s, dir, 1'b0, 1'b1, 1'b1);
        settle();
        put(s, dir, 8'h00);
        settle();
        set_ctl(s, dir, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R6 shown later", got(s, dir), 8'ha5 ^ dir);
        // R8: untouched section still holds zero
        if (s == 0) begin
          set_ctl(1, dir, 1'b0, 1'b1, 1'b0);
          settle();
          chk("R8 other section", got(1, dir), 0);
          set_ctl(1, dir, 1'b1, 1'b1, 1'b1);
        end
        set_ctl(s, dir, 1'b1, 1'b1, 1'b1);
        settle();
      end
    end

    // R10: both directions of each section drive together
    for (int s = 0; s < NS; s++) begin
      set_ctl(s, 0, 1'b0, 1'b1, 1'b0);
      set_ctl(s, 1, 1'b0, 1'b1, 1'b0);
      settle();
      chk("R10 both drive", int'(a_oe[s] & b_oe[s]), 1);
      chk("R10 b word", got(s, 0), 8'ha5);
      chk("R10 a word", got(s, 1), 8'ha4);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule